// File: doc/BRIEF.md
# Playback Control State Machine with Transition Interrupts

This block sequences a sound playback engine through five operating states (init, idle, play, mute and pause) under host control. The host places an 8-bit command code on the command input and pulses a trigger. The block checks whether that command is allowed from the current state. If it is, the state changes on the next clock edge. If it is not, the state stays where it is and a non-fatal command error is recorded.

Each accepted transition belongs to one of four classes, chosen by its destination state: to-idle, to-play, to-pause or to-mute. A per-class mask bit decides whether the transition raises the shared transition flag. A rejected command raises the error flag. The host clears each flag by writing 0 to it through a clear strobe. The interrupt output is asserted only while the global enable bit is set and at least one flag is up. A `playing` output stands in for the audio datapath, which is not part of this block.

Top module: `playback_ctrl`

## Requirements
- R1: After a synchronous reset, the state readback is 0x0000 (init). Both flags, the error bit, the mask, the enable bit, `irq` and `playing` are all 0.
- R2: A triggered command moves the state on the next clock edge, as follows:
  - 0x00 moves init to idle.
  - 0x01 moves idle, mute or pause to play.
  - 0x02 moves play to mute.
  - 0x03 moves play to pause.
  - 0x04 moves play, mute or pause to idle.
  - The readback codes are init 0x0000, idle 0x0001, play 0x0002, mute 0x0003 and pause 0x0004.
- R3: A triggered command with any other code, or one issued from a source state not listed in R2, leaves the state unchanged. On the same edge it sets error bit 0 (`err_cmd`) and the error flag.
- R4: An accepted transition sets the transition flag only if the mask bit of its class is 1. The mask bits are: bit 0 to-idle, bit 1 to-play, bit 2 to-pause, bit 3 to-mute.
- R5: The transition flag is updated on the same clock edge as the state change it reports.
- R6: A clear strobe writes 0 to its flag on the next edge. If a set event occurs on the same edge as the clear, the flag stays 1.
- R7: `irq` is 1 exactly when the enable bit is 1 and at least one flag is 1, and it tracks them on the same edge.
- R8: `playing` is 1 exactly while the state is play.
- R9: Error bit 0 stays set until the next accepted command clears it. Clearing the error flag does not clear error bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 8 | Command code |
| cmd_trig | input | 1 | One-cycle pulse that issues `cmd_code` |
| mask_wr | input | 1 | Write strobe for the transition mask |
| mask_din | input | 4 | New mask value |
| irq_en_wr | input | 1 | Write strobe for the enable bit |
| irq_en_din | input | 1 | New enable value |
| trans_flag_clr | input | 1 | Host writes 0 to the transition flag |
| err_flag_clr | input | 1 | Host writes 0 to the error flag |
| state_code | output | 16 | Current state readback code |
| mask_rd | output | 4 | Current mask value |
| irq_en_rd | output | 1 | Current enable bit |
| trans_flag | output | 1 | State transition interrupt flag |
| err_flag | output | 1 | Error interrupt flag |
| err_cmd | output | 1 | Error bit 0: the last command was rejected |
| irq | output | 1 | Interrupt request |
| playing | output | 1 | High while the state is play |

## Verification
The assertions check several properties on every cycle:
- A rejected command never moves the state, and always raises both the error flag and error bit 0.
- An accepted command always moves the state.
- At most one transition class fires per cycle.
- The transition flag rises only after a masked-in hit.
- Set wins over clear.
- `irq` stays low while the enable bit is off.

Some behaviour can only be shown by the bench's scenarios. These include the exact readback code reached by each command, and the mapping from mask bit positions to transition classes. They also include the persistence of error bit 0 across a flag clear, and `irq` rising on the same edge as the flag that causes it.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PLAY  = 3'd2,
    ST_MUTE  = 3'd3,
    ST_PAUSE = 3'd4
  } pb_state_e;

  localparam int NUM_CLASS = 4;
  localparam int CLS_W     = $clog2(NUM_CLASS);

  localparam int CL_IDLE  = 0;
  localparam int CL_PLAY  = 1;
  localparam int CL_PAUSE = 2;
  localparam int CL_MUTE  = 3;

  localparam int CMD_BOOT  = 0;
  localparam int CMD_PLAY  = 1;
  localparam int CMD_MUTE  = 2;
  localparam int CMD_PAUSE = 3;
  localparam int CMD_STOP  = 4;
endpackage

// File: rtl/pb_fsm.sv
module pb_fsm
  import pb_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CMD_W-1:0]     cmd_code,
  input  logic                 cmd_trig,
  output pb_state_e            state_q,
  output logic                 accept,
  output logic                 reject,
  output logic [NUM_CLASS-1:0] cls_hit
);
  logic            legal;
  pb_state_e       dest;
  logic [CLS_W-1:0] dest_cls;

  always_comb begin
    legal    = 1'b0;
    dest     = state_q;
    dest_cls = '0;
    case (cmd_code)
      CMD_W'(CMD_BOOT): begin
        legal    = (state_q == ST_INIT);
        dest     = ST_IDLE;
        dest_cls = CLS_W'(CL_IDLE);
      end
      CMD_W'(CMD_PLAY): begin
        legal    = (state_q == ST_IDLE) || (state_q == ST_MUTE) || (state_q == ST_PAUSE);
        dest     = ST_PLAY;
        dest_cls = CLS_W'(CL_PLAY);
      end
      CMD_W'(CMD_MUTE): begin
        legal    = (state_q == ST_PLAY);
        dest     = ST_MUTE;
        dest_cls = CLS_W'(CL_MUTE);
      end
      CMD_W'(CMD_PAUSE): begin
        legal    = (state_q == ST_PLAY);
        dest     = ST_PAUSE;
        dest_cls = CLS_W'(CL_PAUSE);
      end
      CMD_W'(CMD_STOP): begin
        legal    = (state_q == ST_PLAY) || (state_q == ST_MUTE) || (state_q == ST_PAUSE);
        dest     = ST_IDLE;
        dest_cls = CLS_W'(CL_IDLE);
      end
      default: legal = 1'b0;
    endcase
  end

  assign accept = cmd_trig & legal;
  assign reject = cmd_trig & ~legal;

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cls
    assign cls_hit[g] = accept && (dest_cls == CLS_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst)         state_q <= ST_INIT;
    else if (accept) state_q <= dest;
  end

  assert_reject_holds_R3: assert property (@(posedge clk) disable iff (rst)
    reject |=> $stable(state_q));
  assert_accept_moves_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state_q != $past(state_q)));
  assert_one_class_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cls_hit));
endmodule

// File: rtl/pb_irq.sv
module pb_irq
  import pb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic                 reject,
  input  logic [NUM_CLASS-1:0] cls_hit,
  input  logic                 mask_wr,
  input  logic [NUM_CLASS-1:0] mask_din,
  input  logic                 en_wr,
  input  logic                 en_din,
  input  logic                 clr_trans,
  input  logic                 clr_err,
  output logic [NUM_CLASS-1:0] mask_q,
  output logic                 en_q,
  output logic                 trans_flag,
  output logic                 err_flag,
  output logic                 err_cmd,
  output logic                 irq
);
  logic [NUM_CLASS-1:0] hit_m;
  logic tf_nxt, ef_nxt, en_nxt, set_trans;

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_gate
    assign hit_m[g] = cls_hit[g] & mask_q[g];
  end
  assign set_trans = |hit_m;

  always_comb begin
    tf_nxt = trans_flag;
    if (set_trans)      tf_nxt = 1'b1;
    else if (clr_trans) tf_nxt = 1'b0;
    ef_nxt = err_flag;
    if (reject)         ef_nxt = 1'b1;
    else if (clr_err)   ef_nxt = 1'b0;
    en_nxt = en_wr ? en_din : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      en_q       <= 1'b0;
      trans_flag <= 1'b0;
      err_flag   <= 1'b0;
      err_cmd    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_din;
      en_q       <= en_nxt;
      trans_flag <= tf_nxt;
      err_flag   <= ef_nxt;
      if (reject)      err_cmd <= 1'b1;
      else if (accept) err_cmd <= 1'b0;
      irq        <= en_nxt & (tf_nxt | ef_nxt);
    end
  end

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq);
  assert_flag_needs_mask_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(trans_flag) |-> $past(set_trans));
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    set_trans |=> trans_flag);
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_trans && !set_trans) |=> !trans_flag);
  assert_err_raised_R3: assert property (@(posedge clk) disable iff (rst)
    reject |=> (err_flag && err_cmd));
endmodule

// File: rtl/playback_ctrl.sv
module playback_ctrl
  import pb_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int STATE_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CMD_W-1:0]     cmd_code,
  input  logic                 cmd_trig,
  input  logic                 mask_wr,
  input  logic [NUM_CLASS-1:0] mask_din,
  input  logic                 irq_en_wr,
  input  logic                 irq_en_din,
  input  logic                 trans_flag_clr,
  input  logic                 err_flag_clr,
  output logic [STATE_W-1:0]   state_code,
  output logic [NUM_CLASS-1:0] mask_rd,
  output logic                 irq_en_rd,
  output logic                 trans_flag,
  output logic                 err_flag,
  output logic                 err_cmd,
  output logic                 irq,
  output logic                 playing
);
  pb_state_e            state_q;
  logic                 accept, reject;
  logic [NUM_CLASS-1:0] cls_hit;

  pb_fsm #(.CMD_W(CMD_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cmd_code (cmd_code),
    .cmd_trig (cmd_trig),
    .state_q  (state_q),
    .accept   (accept),
    .reject   (reject),
    .cls_hit  (cls_hit)
  );

  pb_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .reject     (reject),
    .cls_hit    (cls_hit),
    .mask_wr    (mask_wr),
    .mask_din   (mask_din),
    .en_wr      (irq_en_wr),
    .en_din     (irq_en_din),
    .clr_trans  (trans_flag_clr),
    .clr_err    (err_flag_clr),
    .mask_q     (mask_rd),
    .en_q       (irq_en_rd),
    .trans_flag (trans_flag),
    .err_flag   (err_flag),
    .err_cmd    (err_cmd),
    .irq        (irq)
  );

  assign state_code = STATE_W'(state_q);
  assign playing    = (state_q == ST_PLAY);

  assert_trans_with_move_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(trans_flag) |-> (state_q != $past(state_q)));
endmodule

// File: tb/test_playback_ctrl.sv
`timescale 1ns/1ps
module test_playback_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_code = '0;
  logic        cmd_trig = 1'b0;
  logic        mask_wr = 1'b0;
  logic [3:0]  mask_din = '0;
  logic        irq_en_wr = 1'b0;
  logic        irq_en_din = 1'b0;
  logic        trans_flag_clr = 1'b0;
  logic        err_flag_clr = 1'b0;
  logic [15:0] state_code;
  logic [3:0]  mask_rd;
  logic        irq_en_rd, trans_flag, err_flag, err_cmd, irq, playing;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  playback_ctrl i_playback_ctrl (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .cmd_trig(cmd_trig),
    .mask_wr(mask_wr), .mask_din(mask_din), .irq_en_wr(irq_en_wr),
    .irq_en_din(irq_en_din), .trans_flag_clr(trans_flag_clr),
    .err_flag_clr(err_flag_clr), .state_code(state_code), .mask_rd(mask_rd),
    .irq_en_rd(irq_en_rd), .trans_flag(trans_flag), .err_flag(err_flag),
    .err_cmd(err_cmd), .irq(irq), .playing(playing)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic clr_t = 1'b0);
    @(negedge clk);
    cmd_code = c; cmd_trig = 1'b1; trans_flag_clr = clr_t;
    @(negedge clk);
    cmd_trig = 1'b0; trans_flag_clr = 1'b0;
  endtask

  task automatic set_mask(input logic [3:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_din = m;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  task automatic set_en(input logic e);
    @(negedge clk); irq_en_wr = 1'b1; irq_en_din = e;
    @(negedge clk); irq_en_wr = 1'b0;
  endtask

  task automatic clr_flags(input logic t, input logic e);
    @(negedge clk); trans_flag_clr = t; err_flag_clr = e;
    @(negedge clk); trans_flag_clr = 1'b0; err_flag_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 state", state_code, 16'h0000);
    chk("R1 flags", {trans_flag, err_flag, err_cmd}, 3'b000);
    chk("R1 mask/en", {mask_rd, irq_en_rd}, 5'b0);
    chk("R1 irq/playing", {irq, playing}, 2'b00);
  endtask

  task automatic t_boot_unmasked;
    issue(8'h00);
    chk("R2 init->idle", state_code, 16'h0001);
    chk("R4 masked off no flag", trans_flag, 1'b0);
  endtask

  task automatic t_play_flag;
    set_mask(4'b0010);
    issue(8'h01);
    chk("R2 idle->play", state_code, 16'h0002);
    chk("R5 flag with move", trans_flag, 1'b1);
    chk("R8 playing", playing, 1'b1);
    chk("R7 irq disabled", irq, 1'b0);
    clr_flags(1'b1, 1'b0);
    chk("R6 clear", trans_flag, 1'b0);
  endtask

  task automatic t_errors;
    issue(8'h01);
    chk("R3 illegal play->play state", state_code, 16'h0002);
    chk("R3 err set", {err_flag, err_cmd}, 2'b11);
    issue(8'h07);
    chk("R3 bad code state", state_code, 16'h0002);
    clr_flags(1'b0, 1'b1);
    chk("R9 err flag cleared, bit kept", {err_flag, err_cmd}, 2'b01);
    issue(8'h02);
    chk("R2 play->mute", state_code, 16'h0003);
    chk("R9 valid cmd clears bit", err_cmd, 1'b0);
    chk("R4 to-mute masked", trans_flag, 1'b0);
    chk("R8 not playing in mute", playing, 1'b0);
  endtask

  task automatic t_irq;
    set_mask(4'b1111);
    set_en(1'b1);
    issue(8'h01);
    chk("R2 mute->play", state_code, 16'h0002);
    chk("R7 irq with flag", {trans_flag, irq}, 2'b11);
    set_en(1'b0);
    chk("R7 irq off when disabled", {trans_flag, irq}, 2'b10);
    clr_flags(1'b1, 1'b0);
  endtask

  task automatic t_set_over_clear;
    set_mask(4'b0100);
    issue(8'h03, 1'b1);
    chk("R2 play->pause", state_code, 16'h0004);
    chk("R6 set beats clear", trans_flag, 1'b1);
    clr_flags(1'b1, 1'b0);
  endtask

  task automatic t_stop;
    set_mask(4'b0001);
    issue(8'h04);
    chk("R2 pause->idle", state_code, 16'h0001);
    chk("R4 to-idle flag", trans_flag, 1'b1);
    issue(8'h04);
    chk("R3 stop from idle", {state_code, err_cmd}, {16'h0001, 1'b1});
    issue(8'h02);
    chk("R3 mute from idle", {state_code, err_flag}, {16'h0001, 1'b1});
    issue(8'h00);
    chk("R3 boot from idle", state_code, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_boot_unmasked();
    t_play_flag();
    t_errors();
    t_irq();
    t_set_over_clear();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule